// File: doc/BRIEF.md
# Multi-level priority thread selector

This block chooses which hardware thread a fetch stage serves next. It takes several sets of per-thread occupancy counts, for example counts of entries held in a fetch queue, a reorder buffer, an issue queue and a load/store queue. Each set is one level, and the levels are ranked. Every level supplies one count per thread, and all counts share one width.

Each level compares the counts of threads 1 and up against thread 0's count. A level makes a decision only if some thread has a count strictly below thread 0's. In that case it names the thread holding the smallest count, and on a tie the lowest index wins. A level with no such thread passes the choice down to the next level. If no level decides, thread 0 is chosen.

The selection logic is combinational. An optional output register can be added. A second output reports which level made the choice.

Top module: `fetch_thread_picker`

## Requirements
- R1: Levels are ranked by index, level 0 highest. The output comes from the lowest-numbered level that makes a decision.
- R2: A deciding level selects the thread with the smallest count among threads 1 and up. When several threads share that smallest count, the lowest thread index is selected.
- R3: A level makes a decision only if at least one thread's count is strictly smaller than thread 0's count. A level where thread 0 holds the minimum, alone or tied, gives no decision. As a result, a decided output never names thread 0.
- R4: When a higher-ranked level decides, the counts of every lower-ranked level have no effect on either output.
- R5: When no level decides, `selThread` is 0 and `decidedLevel` is all ones.
- R6: `decidedLevel` carries the index of the deciding level, or all ones for the default case. It never holds a value between NUM_LEVELS and all ones.
- R7: With REG_OUT=1, both outputs change only on a rising clock edge and reflect the counts present at that edge. During reset the outputs read thread 0 and all ones.
- R8: The count of thread t at level l sits at bits `[(l*NUM_THREADS+t)*CNT_W +: CNT_W]` of `levelCounts`. Counts are unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| levelCounts | input | NUM_LEVELS*NUM_THREADS*CNT_W | All per-thread counts of all levels, packed as in R8 |
| selThread | output | max(1,$clog2(NUM_THREADS)) | Selected thread index |
| decidedLevel | output | $clog2(NUM_LEVELS+1) | Level that decided, or all ones for the default |

## Verification
With REG_OUT=1, a fault in a level scan or in the priority strobes shows at the ports one clock after the offending counts are applied. It appears as a wrong thread, a wrong level, or thread 0 reported together with a real level. The bench therefore compares both outputs against a behavioural model on every vector, one edge after the vector is driven. Random counts drawn from a narrow range force frequent ties and frequent cases where thread 0 holds the minimum. Directed vectors target priority fall-through, the strict less-than rule, and the placement of the last count field.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  // Upper bound on the number of priority levels the strobe struct can carry.
  localparam int MAX_LEVELS = 16;

  typedef struct packed {
    logic                  takeDefault;  // no level decided
    logic [MAX_LEVELS-1:0] levelPick;    // one-hot winning level
  } pickStrobes_t;
endpackage

// File: rtl/ftp_level_scan.sv
// Scan of one level: running best starts at thread 0, moves only on strictly smaller counts.
module ftp_level_scan #(
  parameter int NUM_THREADS = 4,
  parameter int CNT_W       = 8,
  parameter int TID_W       = 2
) (
  input  logic [NUM_THREADS*CNT_W-1:0] levelCounts,
  output logic [TID_W-1:0]             bestTid,
  output logic                         beatsThread0
);
  logic [CNT_W-1:0] runCnt;

  always_comb begin
    bestTid      = '0;
    runCnt       = levelCounts[CNT_W-1:0];
    beatsThread0 = 1'b0;
    for (int t = 1; t < NUM_THREADS; t++) begin
      if (levelCounts[t*CNT_W +: CNT_W] < runCnt) begin
        runCnt       = levelCounts[t*CNT_W +: CNT_W];
        bestTid      = TID_W'(t);
        beatsThread0 = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ftp_ctrl.sv
// Priority control: first deciding level (lowest index) wins.
module ftp_ctrl
  import ftp_pkg::*;
#(
  parameter int NUM_LEVELS = 3
) (
  input  logic [NUM_LEVELS-1:0] levelFound,
  output pickStrobes_t          strobes
);
  always_comb begin
    strobes             = '0;
    strobes.takeDefault = 1'b1;
    for (int l = NUM_LEVELS - 1; l >= 0; l--) begin
      if (levelFound[l]) begin
        strobes.levelPick    = '0;
        strobes.levelPick[l] = 1'b1;
        strobes.takeDefault  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ftp_datapath.sv
// Datapath: one scan per level, result mux, optional output register.
module ftp_datapath
  import ftp_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_LEVELS  = 3,
  parameter int CNT_W       = 8,
  parameter bit REG_OUT     = 1'b1,
  parameter int TID_W       = 2,
  parameter int LVL_W       = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_LEVELS*NUM_THREADS*CNT_W-1:0] levelCounts,
  input  pickStrobes_t                          strobes,
  output logic [NUM_LEVELS-1:0]                 levelFound,
  output logic [TID_W-1:0]                      selThread,
  output logic [LVL_W-1:0]                      decidedLevel
);
  localparam int LEVEL_BITS = NUM_THREADS * CNT_W;

  logic [NUM_LEVELS*TID_W-1:0] tidFlat;
  logic [TID_W-1:0]            pickTid;
  logic [LVL_W-1:0]            encLvl;
  logic [TID_W-1:0]            nextTid;
  logic [LVL_W-1:0]            nextLvl;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_level
    ftp_level_scan #(
      .NUM_THREADS(NUM_THREADS),
      .CNT_W      (CNT_W),
      .TID_W      (TID_W)
    ) u_scan (
      .levelCounts (levelCounts[l*LEVEL_BITS +: LEVEL_BITS]),
      .bestTid     (tidFlat[l*TID_W +: TID_W]),
      .beatsThread0(levelFound[l])
    );
  end

  always_comb begin
    pickTid = '0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (strobes.levelPick[l]) pickTid = tidFlat[l*TID_W +: TID_W];
    end
    encLvl = '1;
    for (int l = 0; l < MAX_LEVELS; l++) begin
      if (strobes.levelPick[l]) encLvl = LVL_W'(l);
    end
    nextTid = strobes.takeDefault ? '0 : pickTid;
    nextLvl = strobes.takeDefault ? '1 : encLvl;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selThread    <= '0;
        decidedLevel <= '1;
      end else begin
        selThread    <= nextTid;
        decidedLevel <= nextLvl;
      end
    end
  end else begin : g_comb
    assign selThread    = nextTid;
    assign decidedLevel = nextLvl;
  end
endmodule

// File: rtl/fetch_thread_picker.sv
module fetch_thread_picker
  import ftp_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_LEVELS  = 3,
  parameter int CNT_W       = 8,
  parameter bit REG_OUT     = 1'b1,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_LEVELS*NUM_THREADS*CNT_W-1:0] levelCounts,
  output logic [TID_W-1:0]                      selThread,
  output logic [LVL_W-1:0]                      decidedLevel
);
  logic [NUM_LEVELS-1:0] levelFound;
  pickStrobes_t          strobes;

  ftp_ctrl #(.NUM_LEVELS(NUM_LEVELS)) u_ctrl (
    .levelFound(levelFound),
    .strobes   (strobes)
  );

  ftp_datapath #(
    .NUM_THREADS(NUM_THREADS),
    .NUM_LEVELS (NUM_LEVELS),
    .CNT_W      (CNT_W),
    .REG_OUT    (REG_OUT),
    .TID_W      (TID_W),
    .LVL_W      (LVL_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .levelCounts (levelCounts),
    .strobes     (strobes),
    .levelFound  (levelFound),
    .selThread   (selThread),
    .decidedLevel(decidedLevel)
  );
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_LEVELS  = 3,
  parameter int CNT_W       = 8,
  parameter bit REG_OUT     = 1'b1,
  parameter int TID_W       = 2,
  parameter int LVL_W       = 2
) (
  input logic                                  clk,
  input logic                                  rstN,
  input logic [NUM_LEVELS*NUM_THREADS*CNT_W-1:0] levelCounts,
  input logic [TID_W-1:0]                      selThread,
  input logic [LVL_W-1:0]                      decidedLevel
);
  localparam int TOT = NUM_LEVELS * NUM_THREADS * CNT_W;
  localparam logic [LVL_W-1:0] ALL1 = '1;

  logic [TOT-1:0]   obsCounts;
  logic [CNT_W-1:0] winCnt;
  logic [CNT_W-1:0] zeroCnt;
  logic             higherBeat;

  if (REG_OUT) begin : g_hold
    logic [TOT-1:0] prevCounts;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevCounts <= '0;
      else       prevCounts <= levelCounts;
    end
    assign obsCounts = prevCounts;
  end else begin : g_direct
    assign obsCounts = levelCounts;
  end

  always_comb begin
    winCnt     = '0;
    zeroCnt    = '0;
    higherBeat = 1'b0;
    for (int l = 0; l < NUM_LEVELS; l++) begin
      if (LVL_W'(l) == decidedLevel) begin
        zeroCnt = obsCounts[(l*NUM_THREADS)*CNT_W +: CNT_W];
        for (int t = 0; t < NUM_THREADS; t++) begin
          if (TID_W'(t) == selThread) winCnt = obsCounts[(l*NUM_THREADS+t)*CNT_W +: CNT_W];
        end
      end
      if (decidedLevel != ALL1 && LVL_W'(l) < decidedLevel) begin
        for (int t = 1; t < NUM_THREADS; t++) begin
          if (obsCounts[(l*NUM_THREADS+t)*CNT_W +: CNT_W] < obsCounts[(l*NUM_THREADS)*CNT_W +: CNT_W])
            higherBeat = 1'b1;
        end
      end
    end
  end

  a_r5_default_is_thread0: assert property (@(posedge clk) disable iff (!rstN)
    decidedLevel == ALL1 |-> selThread == '0);

  a_r3_decision_not_thread0: assert property (@(posedge clk) disable iff (!rstN)
    decidedLevel != ALL1 |-> selThread != '0);

  a_r6_level_in_range: assert property (@(posedge clk) disable iff (!rstN)
    decidedLevel == ALL1 || int'(decidedLevel) < NUM_LEVELS);

  a_r3_winner_below_thread0: assert property (@(posedge clk) disable iff (!rstN)
    decidedLevel != ALL1 |-> winCnt < zeroCnt);

  a_r1_higher_levels_silent: assert property (@(posedge clk) disable iff (!rstN)
    decidedLevel != ALL1 |-> !higherBeat);
endmodule

bind fetch_thread_picker ftp_checker #(
  .NUM_THREADS(NUM_THREADS),
  .NUM_LEVELS (NUM_LEVELS),
  .CNT_W      (CNT_W),
  .REG_OUT    (REG_OUT),
  .TID_W      (TID_W),
  .LVL_W      (LVL_W)
) u_ftp_checker (
  .clk         (clk),
  .rstN        (rstN),
  .levelCounts (levelCounts),
  .selThread   (selThread),
  .decidedLevel(decidedLevel)
);

// File: tb/fetch_thread_picker_bench.sv
`timescale 1ns/1ps
module fetch_thread_picker_bench;
  localparam int NT    = 4;
  localparam int NL    = 3;
  localparam int CW    = 8;
  localparam int TOT   = NL * NT * CW;
  localparam int TIDW  = 2;
  localparam int LVLW  = 2;
  localparam int DEFLV = (1 << LVLW) - 1;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [TOT-1:0]  stim = '0;
  logic [TOT-1:0]  pend = '0;
  logic [TIDW-1:0] selThread;
  logic [LVLW-1:0] decidedLevel;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fetch_thread_picker #(.NUM_THREADS(NT), .NUM_LEVELS(NL), .CNT_W(CW), .REG_OUT(1'b1))
    u_fetch_thread_picker (
      .clk(clk), .rstN(rstN), .levelCounts(stim),
      .selThread(selThread), .decidedLevel(decidedLevel));

  function automatic void put(int l, int t, int v);
    pend[(l*NT+t)*CW +: CW] = CW'(v);
  endfunction

  function automatic void fillAll(int v);
    for (int l = 0; l < NL; l++)
      for (int t = 0; t < NT; t++) put(l, t, v);
  endfunction

  // Behavioural reference: per level, find the minimum of threads 1.., then the first index holding it.
  task automatic model(input logic [TOT-1:0] c, output int eTid, output int eLvl);
    eTid = 0;
    eLvl = DEFLV;
    for (int l = NL - 1; l >= 0; l--) begin
      int base;
      int mn;
      base = int'(c[(l*NT)*CW +: CW]);
      mn = 1 << CW;
      for (int t = 1; t < NT; t++)
        if (int'(c[(l*NT+t)*CW +: CW]) < mn) mn = int'(c[(l*NT+t)*CW +: CW]);
      if (mn < base) begin
        for (int t = NT - 1; t >= 1; t--)
          if (int'(c[(l*NT+t)*CW +: CW]) == mn) eTid = t;
        eLvl = l;
      end
    end
  endtask

  task automatic compare(string tag, int eTid, int eLvl);
    checks++;
    if (int'(selThread) != eTid || int'(decidedLevel) != eLvl) begin
      failures++;
      $display("FAIL %s: thread=%0d level=%0d expected thread=%0d level=%0d",
               tag, selThread, decidedLevel, eTid, eLvl);
    end
  endtask

  // Drive at a falling edge; the output register captures at the next rising edge; sample at the following falling edge.
  task automatic apply(string tag);
    int eTid;
    int eLvl;
    @(negedge clk);
    stim = pend;
    model(pend, eTid, eLvl);
    @(negedge clk);
    compare(tag, eTid, eLvl);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: thread=%0d level=%0d expected thread=x level=x", selThread, decidedLevel);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R7: reset values
    fillAll(0);
    put(0, 1, 0);
    stim = '0;
    repeat (3) @(negedge clk);
    compare("R7 reset", 0, DEFLV);
    rstN = 1'b1;
    @(negedge clk);

    // R5/R3: all equal, no level decides
    fillAll(10);
    apply("R5 all tied");

    // R3: thread 0 strictly smallest on every level
    fillAll(20);
    for (int l = 0; l < NL; l++) put(l, 0, 3);
    apply("R3 thread0 minimum");

    // R1/R6: level 0 decides
    fillAll(20);
    put(0, 2, 5);
    put(1, 1, 1);
    apply("R1 level0 decides");

    // R1/R6: level 0 tied with thread 0, level 1 decides
    fillAll(20);
    put(0, 0, 4); put(0, 3, 4);
    put(1, 3, 7);
    apply("R6 fall to level1");

    // R2: tie among threads below thread 0, lowest index wins
    fillAll(9);
    put(0, 1, 3); put(0, 2, 3); put(0, 3, 3);
    apply("R2 tie lowest index");

    // R2: running minimum tracks the smallest, not the first smaller
    fillAll(9);
    put(0, 0, 50); put(0, 1, 40); put(0, 2, 30); put(0, 3, 35);
    apply("R2 running minimum");

    // R4: lower-level counts changed while level 0 decides
    fillAll(30);
    put(0, 3, 2);
    put(1, 1, 0); put(2, 2, 0);
    apply("R4 lower levels A");
    put(1, 1, 200); put(1, 2, 0); put(2, 1, 0); put(2, 0, 0);
    apply("R4 lower levels B");

    // R8: last field of last level decides
    fillAll(100);
    put(NL - 1, NT - 1, 99);
    apply("R8 last field");

    // R8: unsigned extremes
    fillAll(0);
    put(1, 0, 255); put(1, 2, 254);
    apply("R8 unsigned extremes");

    // R7: output holds until the rising edge
    fillAll(7);
    apply("R7 settle default");
    @(negedge clk);
    fillAll(7);
    put(0, 2, 1);
    stim = pend;
    #1;
    compare("R7 before edge", 0, DEFLV);
    @(negedge clk);
    compare("R7 after edge", 2, 0);

    // R1/R2/R3: random narrow-range counts force ties
    for (int i = 0; i < 300; i++) begin
      for (int l = 0; l < NL; l++)
        for (int t = 0; t < NT; t++) put(l, t, int'($urandom_range(0, 3)));
      apply("R2 random narrow");
    end
    for (int i = 0; i < 100; i++) begin
      for (int l = 0; l < NL; l++)
        for (int t = 0; t < NT; t++) put(l, t, int'($urandom_range(0, 255)));
      apply("R1 random wide");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule